// File: doc/BRIEF.md
# Floating-point register stack

This block is an eight-deep file of 80-bit registers run as a circular stack. Software-visible positions are counted from a moving head. Slot 0 is the newest entry, and slot 1 is the one beneath it. Deeper slots follow in the same way. Internally a 3-bit head pointer picks the physical register, and a per-register tag marks whether it holds a value.

Commands arrive on a valid-qualified port, one per clock. A command can:
- push an operand;
- push a built-in constant;
- pop one or two entries;
- write any slot, then pop zero, one or two entries;
- swap the head with any slot;
- copy the head into a slot and then pop;
- empty the stack.

The command port never applies back-pressure. Every cycle with `cmd_valid` high is a consumed command, so there is no ready signal. A combinational read port returns the value and tag of any slot. Faulting commands change nothing and raise a one-cycle flag instead.

Top module: `fp_regstack`

## Requirements
- R1: After reset, and on the edge after an initialise command (`cmd_op`=7), every slot reads back empty (`rd_valid`=0) and neither flag is raised.
- R2: A push of `cmd_data` (`cmd_op`=1) on a stack that is not full puts the operand in slot 0. The entry that was in slot k moves to slot k+1.
- R3: A constant push (`cmd_op`=2) pushes a value without an operand. When `cmd_const`=0 the value is all zeros. When `cmd_const`=1 the value is 1.0, encoded as 80'h3FFF_8000_0000_0000_0000.
- R4: A push of either kind with eight entries present raises `err_overflow` for exactly the cycle after the command. All contents and tags stay unchanged.
- R5: A pop (`cmd_op`=3) discards slot 0. With `cmd_pops`=2 it discards slots 0 and 1 in one command. Any other `cmd_pops` value pops one entry.
- R6: A write (`cmd_op`=4) stores `cmd_data` into slot `cmd_slot`. It then pops 0, 1 or 2 entries for `cmd_pops` = 0, 1, or 2/3.
- R7: An exchange (`cmd_op`=5) swaps the contents of slot 0 and slot `cmd_slot` in one command. Slot 0 with itself leaves the stack unchanged.
- R8: A store-and-pop (`cmd_op`=6) copies slot 0 into slot `cmd_slot` and then pops once. The result equals an exchange with that slot followed by a pop.
- R9: A command that would read, pop, write or swap an empty slot raises `err_underflow` for exactly the cycle after the command. It leaves all state unchanged. This includes a pop count larger than the number of entries.
- R10: `rd_data` and `rd_valid` show the addressed slot `rd_slot` combinationally. State changes are visible right after the accepting clock edge.
- R11: With `cmd_valid` low the stack keeps its state and raises no flag, whatever the other command inputs hold. `cmd_op`=0 is a no-operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle; always consumed |
| cmd_op | input | 3 | Command code (0 none, 1 push, 2 constant, 3 pop, 4 write, 5 exchange, 6 store-and-pop, 7 initialise) |
| cmd_slot | input | 3 | Slot offset from the head for write, exchange and store-and-pop |
| cmd_pops | input | 2 | Pop count for write and pop |
| cmd_const | input | 1 | Constant select: 0 zero, 1 one |
| cmd_data | input | 80 | Operand for push and write |
| rd_slot | input | 3 | Slot offset to read |
| rd_data | output | 80 | Contents of the addressed slot |
| rd_valid | output | 1 | Addressed slot holds a value |
| err_overflow | output | 1 | Previous command was a push onto a full stack |
| err_underflow | output | 1 | Previous command touched an empty slot |

## Verification
A wrong head pointer or a stray tag shows up right after the edge that caused it. The sweep of all eight slots then finds values in the wrong order, or `rd_valid` set at the wrong depth. A tag left set or cleared by mistake also shows one command later. A flag then appears where none belongs, or fails to appear, because the stack fills or empties one entry early. A slot reaches the read port only through the pointer offset. For that reason every command is followed by a full slot sweep compared against an ordered-list model, and no corruption outlives one cycle unseen.

// File: rtl/fps_pkg.sv
`timescale 1ns/1ps
package fps_pkg;
  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_PUSH  = 3'd1,
    OP_CONST = 3'd2,
    OP_POP   = 3'd3,
    OP_WRITE = 3'd4,
    OP_SWAP  = 3'd5,
    OP_STPOP = 3'd6,
    OP_INIT  = 3'd7
  } fps_op_e;

  localparam logic [79:0] K_ZERO = 80'h0;
  localparam logic [79:0] K_ONE  = {1'b0, 15'h3FFF, 1'b1, 63'h0};

  function automatic logic [79:0] builtin(input logic sel);
    return sel ? K_ONE : K_ZERO;
  endfunction
endpackage

// File: rtl/fps_bank.sv
`timescale 1ns/1ps
module fps_bank #(
  parameter int W     = 80,
  parameter int DEPTH = 8,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic                      wa_en,
  input  logic [PW-1:0]             wa_idx,
  input  logic [W-1:0]              wa_val,
  input  logic                      wb_en,
  input  logic [PW-1:0]             wb_idx,
  input  logic [W-1:0]              wb_val,
  output logic [DEPTH-1:0][W-1:0]   q
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int g = 0; g < DEPTH; g++) begin
      if (wa_en && wa_idx == PW'(g))      mem[g] <= wa_val;
      else if (wb_en && wb_idx == PW'(g)) mem[g] <= wb_val;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_out
    assign q[g] = mem[g];
  end
endmodule

// File: rtl/fps_state.sv
`timescale 1ns/1ps
module fps_state #(
  parameter int DEPTH = 8,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PW-1:0]    top_nxt,
  input  logic [DEPTH-1:0] tag_set,
  input  logic [DEPTH-1:0] tag_clr,
  input  logic             ovf,
  input  logic             unf,
  output logic [PW-1:0]    top,
  output logic [DEPTH-1:0] tags,
  output logic             err_ovf,
  output logic             err_unf
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      top     <= '0;
      tags    <= '0;
      err_ovf <= 1'b0;
      err_unf <= 1'b0;
    end else begin
      top     <= top_nxt;
      tags    <= (tags & ~tag_clr) | tag_set;
      err_ovf <= ovf;
      err_unf <= unf;
    end
  end

  assert_flags_apart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_ovf && err_unf));
endmodule

// File: rtl/fps_ctrl.sv
`timescale 1ns/1ps
module fps_ctrl
  import fps_pkg::*;
#(
  parameter int W     = 80,
  parameter int DEPTH = 8,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_valid,
  input  fps_op_e                  op,
  input  logic [PW-1:0]            slot,
  input  logic [1:0]               pops,
  input  logic                     ksel,
  input  logic [W-1:0]             data,
  input  logic [PW-1:0]            top,
  input  logic [DEPTH-1:0]         tags,
  input  logic [DEPTH-1:0][W-1:0]  q,
  output logic                     wa_en,
  output logic [PW-1:0]            wa_idx,
  output logic [W-1:0]             wa_val,
  output logic                     wb_en,
  output logic [PW-1:0]            wb_idx,
  output logic [W-1:0]             wb_val,
  output logic [PW-1:0]            top_nxt,
  output logic [DEPTH-1:0]         tag_set,
  output logic [DEPTH-1:0]         tag_clr,
  output logic                     ovf,
  output logic                     unf
);
  logic [PW-1:0] i_head, i_next, i_slot, i_above;
  logic          v_head, v_next, v_slot, full;
  logic [PW-1:0] npop;

  assign i_head  = top;
  assign i_next  = top + PW'(1);
  assign i_slot  = top + slot;
  assign i_above = top - PW'(1);
  assign v_head  = tags[i_head];
  assign v_next  = tags[i_next];
  assign v_slot  = tags[i_slot];
  assign full    = tags[i_above];

  always_comb begin
    wa_en   = 1'b0;
    wa_idx  = i_slot;
    wa_val  = data;
    wb_en   = 1'b0;
    wb_idx  = i_head;
    wb_val  = q[i_slot];
    top_nxt = top;
    tag_set = '0;
    tag_clr = '0;
    ovf     = 1'b0;
    unf     = 1'b0;
    npop    = '0;
    if (cmd_valid) begin
      unique case (op)
        OP_PUSH, OP_CONST: begin
          if (full) ovf = 1'b1;
          else begin
            wa_en           = 1'b1;
            wa_idx          = i_above;
            wa_val          = (op == OP_PUSH) ? data : W'(builtin(ksel));
            tag_set[i_above] = 1'b1;
            top_nxt         = i_above;
          end
        end
        OP_POP: begin
          npop = (pops == 2'd2) ? PW'(2) : PW'(1);
          if ((pops == 2'd2) ? !v_next : !v_head) unf = 1'b1;
          else begin
            tag_clr[i_head] = 1'b1;
            if (pops == 2'd2) tag_clr[i_next] = 1'b1;
            top_nxt = top + npop;
          end
        end
        OP_WRITE: begin
          npop = (pops == 2'd0) ? PW'(0) : (pops == 2'd1) ? PW'(1) : PW'(2);
          if (!v_slot || (pops == 2'd1 && !v_head) || (pops[1] && !v_next)) unf = 1'b1;
          else begin
            wa_en = 1'b1;
            if (pops != 2'd0) tag_clr[i_head] = 1'b1;
            if (pops[1])      tag_clr[i_next] = 1'b1;
            top_nxt = top + npop;
          end
        end
        OP_SWAP: begin
          if (!v_head || !v_slot) unf = 1'b1;
          else begin
            wa_en  = 1'b1;
            wa_val = q[i_head];
            wb_en  = (slot != '0);
          end
        end
        OP_STPOP: begin
          if (!v_head || !v_slot) unf = 1'b1;
          else begin
            wa_en           = 1'b1;
            wa_val          = q[i_head];
            tag_clr[i_head] = 1'b1;
            top_nxt         = i_next;
          end
        end
        OP_INIT: begin
          tag_clr = '1;
          top_nxt = '0;
        end
        default: ;
      endcase
    end
  end

  assert_ports_apart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wa_en && wb_en) |-> (wa_idx != wb_idx));
  assert_fault_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf || unf) |-> (!wa_en && !wb_en && tag_set == '0 && tag_clr == '0));
endmodule

// File: rtl/fp_regstack.sv
`timescale 1ns/1ps
module fp_regstack
  import fps_pkg::*;
#(
  parameter int W     = 80,
  parameter int DEPTH = 8,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [PW-1:0] cmd_slot,
  input  logic [1:0]    cmd_pops,
  input  logic          cmd_const,
  input  logic [W-1:0]  cmd_data,
  input  logic [PW-1:0] rd_slot,
  output logic [W-1:0]  rd_data,
  output logic          rd_valid,
  output logic          err_overflow,
  output logic          err_underflow
);
  fps_op_e                op;
  logic [PW-1:0]          top, top_nxt, wa_idx, wb_idx, i_rd;
  logic [DEPTH-1:0]       tags, tag_set, tag_clr;
  logic [DEPTH-1:0][W-1:0] q;
  logic                   wa_en, wb_en, ovf, unf;
  logic [W-1:0]           wa_val, wb_val;

  assign op = fps_op_e'(cmd_op);

  fps_ctrl #(.W(W), .DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .op(op), .slot(cmd_slot),
    .pops(cmd_pops), .ksel(cmd_const), .data(cmd_data), .top(top), .tags(tags),
    .q(q), .wa_en(wa_en), .wa_idx(wa_idx), .wa_val(wa_val), .wb_en(wb_en),
    .wb_idx(wb_idx), .wb_val(wb_val), .top_nxt(top_nxt), .tag_set(tag_set),
    .tag_clr(tag_clr), .ovf(ovf), .unf(unf)
  );

  fps_state #(.DEPTH(DEPTH)) u_state (
    .clk(clk), .rst_n(rst_n), .top_nxt(top_nxt), .tag_set(tag_set),
    .tag_clr(tag_clr), .ovf(ovf), .unf(unf), .top(top), .tags(tags),
    .err_ovf(err_overflow), .err_unf(err_underflow)
  );

  fps_bank #(.W(W), .DEPTH(DEPTH)) u_bank (
    .clk(clk), .wa_en(wa_en), .wa_idx(wa_idx), .wa_val(wa_val),
    .wb_en(wb_en), .wb_idx(wb_idx), .wb_val(wb_val), .q(q)
  );

  assign i_rd     = top + rd_slot;
  assign rd_data  = q[i_rd];
  assign rd_valid = tags[i_rd];

  assert_init_empties_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && op == OP_INIT) |=> (tags == '0 && top == '0));
  assert_push_moves_head_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (op == OP_PUSH || op == OP_CONST) && tags != '1)
      |=> (top == $past(top) - PW'(1)));
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (op == OP_PUSH || op == OP_CONST) && tags == '1)
      |=> (err_overflow && $stable(tags) && $stable(top)));
  assert_underflow_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    unf |=> (err_underflow && $stable(tags) && $stable(top)));
  assert_idle_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> ($stable(tags) && $stable(top) && !err_overflow && !err_underflow));
endmodule

// File: tb/test_fp_regstack.sv
`timescale 1ns/1ps
module test_fp_regstack;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_const = 1'b0;
  logic [2:0]  cmd_op = 3'd0, cmd_slot = 3'd0, rd_slot = 3'd0;
  logic [1:0]  cmd_pops = 2'd0;
  logic [79:0] cmd_data = '0, rd_data;
  logic        rd_valid, err_overflow, err_underflow;

  always #4 clk = ~clk;

  fp_regstack i_fp_regstack (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_slot(cmd_slot), .cmd_pops(cmd_pops), .cmd_const(cmd_const),
    .cmd_data(cmd_data), .rd_slot(rd_slot), .rd_data(rd_data),
    .rd_valid(rd_valid), .err_overflow(err_overflow), .err_underflow(err_underflow)
  );

  localparam logic [79:0] ONE_X = {1'b0, 15'h3FFF, 1'b1, 63'h0};
  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [79:0] m [8];
  int cnt = 0;
  logic [31:0] r = 32'h1ACE_B00C;

  function automatic string req_of(int op);
    case (op)
      1: return "R2"; 2: return "R3"; 3: return "R5"; 4: return "R6";
      5: return "R7"; 6: return "R8"; 7: return "R1"; default: return "R11";
    endcase
  endfunction

  task automatic check(bit ok, string req, logic [79:0] act, logic [79:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic sweep(string req);
    bit ok = 1;
    logic [79:0] a = '0, e = '0;
    for (int s = 0; s < 8; s++) begin
      rd_slot = 3'(s);
      #0.2;
      if (rd_valid !== (s < cnt)) begin
        ok = 0; a = {79'(s), rd_valid}; e = {79'(s), 1'b1 & (s < cnt)};
      end else if (s < cnt && rd_data !== m[s]) begin
        ok = 0; a = rd_data; e = m[s];
      end
    end
    check(ok, {req, " R10 slot sweep"}, a, e);
  endtask

  task automatic pop_n(int np);
    for (int j = 0; j < np; j++) begin
      for (int i = 0; i < 7; i++) m[i] = m[i + 1];
      cnt--;
    end
  endtask

  task automatic do_cmd(bit v, int op, int slot, int pops, bit k, logic [79:0] d);
    bit eo = 0, eu = 0;
    int np;
    logic [79:0] t;
    @(negedge clk);
    cmd_valid = v; cmd_op = 3'(op); cmd_slot = 3'(slot);
    cmd_pops = 2'(pops); cmd_const = k; cmd_data = d;
    if (v) begin
      case (op)
        1, 2: if (cnt == 8) eo = 1;
              else begin
                for (int i = 7; i > 0; i--) m[i] = m[i - 1];
                m[0] = (op == 1) ? d : (k ? ONE_X : 80'h0);
                cnt++;
              end
        3: begin np = (pops == 2) ? 2 : 1; if (cnt < np) eu = 1; else pop_n(np); end
        4: begin
             np = (pops == 0) ? 0 : (pops == 1) ? 1 : 2;
             if (slot >= cnt || cnt < np) eu = 1;
             else begin m[slot] = d; pop_n(np); end
           end
        5: if (slot >= cnt) eu = 1;
           else begin t = m[0]; m[0] = m[slot]; m[slot] = t; end
        6: if (slot >= cnt) eu = 1;
           else begin t = m[0]; m[0] = m[slot]; m[slot] = t; pop_n(1); end
        7: cnt = 0;
        default: ;
      endcase
    end
    @(posedge clk);
    #1;
    cmd_valid = 1'b0;
    check(err_overflow === eo, "R4 overflow flag", 80'(err_overflow), 80'(eo));
    check(err_underflow === eu, "R9 underflow flag", 80'(err_underflow), 80'(eu));
    sweep(v ? req_of(op) : "R11");
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] x);
    logic [31:0] y = x;
    y ^= y << 13; y ^= y >> 17; y ^= y << 5;
    return y;
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int op, sl, pp;
    logic [79:0] d;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    check(!err_overflow && !err_underflow, "R1 flags after reset",
          80'({err_overflow, err_underflow}), 80'h0);
    sweep("R1");
    // R9/R5 pops on empty stack
    do_cmd(1, 3, 0, 1, 0, '0);
    do_cmd(1, 3, 0, 2, 0, '0);
    // R2 fill with eight operands
    for (int i = 0; i < 8; i++)
      do_cmd(1, 1, 0, 0, 0, {16'hA000 + 16'(i), 64'(i) * 64'h0101_0101_0101_0101});
    // R4 ninth push of both kinds
    do_cmd(1, 1, 0, 0, 0, 80'hDEAD);
    do_cmd(1, 2, 0, 0, 1, '0);
    // R7 exchange each slot
    for (int n = 0; n < 8; n++) do_cmd(1, 5, n, 0, 0, '0);
    // R6 write each slot without popping
    for (int n = 0; n < 8; n++) do_cmd(1, 4, n, 0, 0, {64'hC0DE, 16'(n)});
    // R11 idle with a push on the bus
    do_cmd(0, 1, 0, 0, 0, 80'hBAD);
    do_cmd(1, 0, 3, 2, 1, 80'hBAD);
    // R8 store-and-pop, R5 double pop, R6 write with pops
    do_cmd(1, 6, 3, 0, 0, '0);
    do_cmd(1, 3, 0, 2, 0, '0);
    do_cmd(1, 4, 1, 1, 0, 80'h1234_5678);
    do_cmd(1, 4, 0, 2, 0, 80'h9999);
    do_cmd(1, 4, 2, 3, 0, 80'h7777);
    do_cmd(1, 6, 0, 0, 0, '0);
    // R9 write and swap below the bottom
    do_cmd(1, 4, 7, 0, 0, 80'h1);
    do_cmd(1, 5, 6, 0, 0, '0);
    // R3 constants
    do_cmd(1, 2, 0, 0, 0, '0);
    do_cmd(1, 2, 0, 0, 1, '0);
    // R1 initialise
    do_cmd(1, 7, 0, 0, 0, '0);
    // pseudo-random sweep of commands
    for (int it = 0; it < 600; it++) begin
      r = nxt(r);
      op = int'(r[2:0]);
      if (op == 7 && r[3]) op = 1;
      if (op == 0 && r[4]) op = 2;
      sl = int'(r[9:7]);
      pp = int'(r[6:5]);
      d[79:48] = r; r = nxt(r); d[47:16] = r; d[15:0] = r[31:16];
      do_cmd(r[11] | r[12], op, sl, pp, r[10], d);
    end
    summary();
  end
endmodule